// File: doc/BRIEF.md
# Dual ROM/SRAM chip-select decoder

This block models a byte-wide memory device that puts a read-only array and a small read/write array behind one shared address bus and one data path. Two active-low select inputs choose an array. An active-low read strobe and an active-low write strobe set the direction of the transfer. Every clock edge decodes the four control lines into one operating mode. In that mode the block either returns a byte from the chosen array, stores the incoming byte into the read/write array, or leaves the output disabled.

The data bus is split in two so that the design stays synthesizable. There is an input byte, an output byte, and a flag that says when the output byte would be driven onto a shared bus. Reads are registered, so the byte and its drive flag appear one cycle after the request. The read-only array is not stored anywhere: each byte is computed from its address by a seeded folding pattern. The read/write array looks only at the low address bits. The read-only array uses the full address width.

Top module: `dual_array_mem`

## Requirements
- R1: After a clock edge with `rst_n` low, `data_oe` is 0 and `data_out` is 0.
- R2: When `rom_sel_n` and `ram_sel_n` are both 1, `data_oe` is 0 in the following cycle, whatever `rd_en_n` and `wr_en_n` are.
- R3: When `rom_sel_n` is 0, `ram_sel_n` is 1 and `rd_en_n` is 0, in the following cycle `data_oe` is 1 and `data_out` equals `SEED ^ addr[7:0] ^ addr[15:8] ^ {6'b0, addr[17:16]}`, with `SEED` = 8'hA5 by default. `wr_en_n` has no effect on this.
- R4: When `ram_sel_n` is 0, `rom_sel_n` is 1, `wr_en_n` is 1 and `rd_en_n` is 0, in the following cycle `data_oe` is 1 and `data_out` holds the byte most recently written at `addr[RAM_AW-1:0]`.
- R5: When an array is selected and `rd_en_n` is 1, `data_oe` is 0 in the following cycle.
- R6: When `ram_sel_n` is 0, `rom_sel_n` is 1 and `wr_en_n` is 0, `din` is stored at `addr[RAM_AW-1:0]` on that clock edge, whatever `rd_en_n` is. `data_oe` is 0 in the following cycle, so a write never drives the output. This also covers a select that goes low together with, or after, the write strobe.
- R7: When `rom_sel_n` and `ram_sel_n` are both 0, `data_oe` is 0 in the following cycle and no write happens, even if `wr_en_n` is 0.
- R8: The read/write array ignores `addr[ROM_AW-1:RAM_AW]`. Addresses that differ only in those bits reach the same byte.
- R9: A write strobe while only the read-only array is selected changes no byte of the read/write array.
- R10: A read of a read/write address in the cycle right after a write to that address returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ROM_AW | Shared byte address |
| din | input | DW | Byte to be written |
| rom_sel_n | input | 1 | Read-only array select, active low |
| ram_sel_n | input | 1 | Read/write array select, active low |
| rd_en_n | input | 1 | Read strobe, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| data_out | output | DW | Registered read byte |
| data_oe | output | 1 | Output drive flag, high when data_out is valid |

## Verification
Two functions can collide in a single cycle. The first is a read of the read-only array while the write strobe is also low. The bench provokes this by sweeping read-only addresses with the write strobe toggling every cycle and a varying `din` on the bus. It then judges the result two ways: each returned byte must match the address formula, and a later read-back of the whole read/write array must show it unchanged. The second collision is a write followed, in the very next cycle, by a read of the same location. The bench issues this pair back to back with the address alias bits changed in between, and expects the new byte.

// File: rtl/dual_array_mem_pkg.sv
// Package: shared mode encoding for the dual-array memory model.
package dual_array_mem_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_ROM_RD = 2'd1,
        MODE_RAM_RD = 2'd2,
        MODE_RAM_WR = 2'd3
    } mem_mode_t;
endpackage

// File: rtl/dual_array_mem_dec.sv
// Module: dual_array_mem_dec
// Turns the four active-low control lines into one operating mode.
// Assumes the inputs are already synchronous to the consuming clock.
// Selecting both arrays at once counts as selecting none.
module dual_array_mem_dec
    import dual_array_mem_pkg::*;
(
    input  logic      rom_sel_n,
    input  logic      ram_sel_n,
    input  logic      rd_en_n,
    input  logic      wr_en_n,
    output mem_mode_t mode
);
    // Purpose: priority decode; a write to RAM outranks the read strobe.
    always_comb begin
        mode = MODE_OFF;
        if (!rom_sel_n && ram_sel_n) begin
            if (!rd_en_n) mode = MODE_ROM_RD;
        end else if (rom_sel_n && !ram_sel_n) begin
            if (!wr_en_n)      mode = MODE_RAM_WR;
            else if (!rd_en_n) mode = MODE_RAM_RD;
        end
    end
endmodule

// File: rtl/dual_array_mem_rom.sv
// Module: dual_array_mem_rom
// Computes the read-only array content from the address, with no storage.
// Each byte is SEED XORed with every DW-bit slice of the address.
// Assumes ROM_AW >= DW.
module dual_array_mem_rom #(
    parameter int          ROM_AW = 18,
    parameter int          DW     = 8,
    parameter logic [DW-1:0] SEED = 8'hA5
) (
    input  logic [ROM_AW-1:0] addr,
    output logic [DW-1:0]     rd_byte
);
    localparam int NSLICE = (ROM_AW + DW - 1) / DW;

    // Purpose: fold the address slices into one byte.
    always_comb begin
        logic [ROM_AW-1:0] sh;
        rd_byte = SEED;
        for (int k = 0; k < NSLICE; k++) begin
            sh      = addr >> (k * DW);
            rd_byte = rd_byte ^ sh[DW-1:0];
        end
    end
endmodule

// File: rtl/dual_array_mem_ram.sv
// Module: dual_array_mem_ram
// Read/write byte array with a clocked write port and a combinational read.
// A write and a read of the same word in adjacent cycles see the new value.
// The contents are not reset.
module dual_array_mem_ram #(
    parameter int RAM_AW = 10,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [RAM_AW-1:0] waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [RAM_AW-1:0] raddr,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: store the write byte on the clock edge.
    always_ff @(posedge clk) begin
        if (wr) mem[waddr] <= wdata;
    end

    // Purpose: present the addressed word for the output register.
    assign rdata = mem[raddr];
endmodule

// File: rtl/dual_array_mem.sv
// Module: dual_array_mem (top)
// Byte-wide device model that joins a computed read-only array and a
// read/write array on one address bus. The tri-state bus is modelled as an
// output byte plus a drive flag. Reads are registered with one cycle of
// latency. The read/write array uses only the low RAM_AW address bits.
// Assumes a synchronous active-low reset.
module dual_array_mem
    import dual_array_mem_pkg::*;
#(
    parameter int            ROM_AW = 18,
    parameter int            RAM_AW = 10,
    parameter int            DW     = 8,
    parameter logic [DW-1:0] SEED   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROM_AW-1:0] addr,
    input  logic [DW-1:0]     din,
    input  logic              rom_sel_n,
    input  logic              ram_sel_n,
    input  logic              rd_en_n,
    input  logic              wr_en_n,
    output logic [DW-1:0]     data_out,
    output logic              data_oe
);
    mem_mode_t         mode;
    logic [DW-1:0]     rom_byte;
    logic [DW-1:0]     ram_byte;
    logic [RAM_AW-1:0] ram_addr;
    logic [DW-1:0]     dout_q;
    logic              oe_q;

    assign ram_addr = addr[RAM_AW-1:0];

    dual_array_mem_dec u_dec (
        .rom_sel_n (rom_sel_n),
        .ram_sel_n (ram_sel_n),
        .rd_en_n   (rd_en_n),
        .wr_en_n   (wr_en_n),
        .mode      (mode)
    );

    dual_array_mem_rom #(.ROM_AW(ROM_AW), .DW(DW), .SEED(SEED)) u_rom (
        .addr    (addr),
        .rd_byte (rom_byte)
    );

    dual_array_mem_ram #(.RAM_AW(RAM_AW), .DW(DW)) u_ram (
        .clk   (clk),
        .wr    (mode == MODE_RAM_WR),
        .waddr (ram_addr),
        .wdata (din),
        .raddr (ram_addr),
        .rdata (ram_byte)
    );

    // Purpose: register the read byte and its drive flag for the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            case (mode)
                MODE_ROM_RD: begin
                    oe_q   <= 1'b1;
                    dout_q <= rom_byte;
                end
                MODE_RAM_RD: begin
                    oe_q   <= 1'b1;
                    dout_q <= ram_byte;
                end
                default: oe_q <= 1'b0;
            endcase
        end
    end

    assign data_out = dout_q;
    assign data_oe  = oe_q;
endmodule

// File: rtl/dual_array_mem_chk.sv
// Module: dual_array_mem_chk
// Watches the ports of dual_array_mem and checks how the drive flag follows
// the control lines. It is attached through the bind below.
module dual_array_mem_chk #(
    parameter int ROM_AW = 18,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ROM_AW-1:0] addr,
    input logic              rom_sel_n,
    input logic              ram_sel_n,
    input logic              rd_en_n,
    input logic              wr_en_n,
    input logic [DW-1:0]     data_out,
    input logic              data_oe
);
    assert_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel_n && ram_sel_n) |=> !data_oe);

    assert_rom_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_sel_n && ram_sel_n && !rd_en_n) |=> data_oe);

    assert_ram_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel_n && !ram_sel_n && wr_en_n && !rd_en_n) |=> data_oe);

    assert_rd_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_n |=> !data_oe);

    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel_n && !ram_sel_n && !wr_en_n) |=> !data_oe);

    assert_both_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_sel_n && !ram_sel_n) |=> !data_oe);

    // R3: a repeated ROM read of a steady address returns a steady byte.
    assert_rom_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_sel_n && ram_sel_n && !rd_en_n && $stable(addr)
         && $past(!rom_sel_n && ram_sel_n && !rd_en_n)) |=> $stable(data_out));
endmodule

bind dual_array_mem dual_array_mem_chk #(.ROM_AW(ROM_AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .rom_sel_n (rom_sel_n),
    .ram_sel_n (ram_sel_n),
    .rd_en_n   (rd_en_n),
    .wr_en_n   (wr_en_n),
    .data_out  (data_out),
    .data_oe   (data_oe)
);

// File: tb/dual_array_mem_tb.sv
module dual_array_mem_tb;
    localparam int ROM_AW = 18;
    localparam int RAM_AW = 10;
    localparam int DW     = 8;
    localparam int DEPTH  = 1 << RAM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ROM_AW-1:0] addr = '0;
    logic [DW-1:0]     din = '0;
    logic              rom_sel_n = 1'b1;
    logic              ram_sel_n = 1'b1;
    logic              rd_en_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic [DW-1:0]     data_out;
    logic              data_oe;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];

    always #4 clk = ~clk;

    dual_array_mem #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n),
        .rd_en_n(rd_en_n), .wr_en_n(wr_en_n),
        .data_out(data_out), .data_oe(data_oe)
    );

    function automatic logic [7:0] rom_exp(input logic [17:0] a);
        return 8'hA5 ^ a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]};
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: drive at a falling edge, results visible at the next falling edge.
    task automatic op(input logic [17:0] a, input logic [7:0] d,
                      input logic rom_n, input logic ram_n,
                      input logic rd_n, input logic wr_n);
        addr = a; din = d; rom_sel_n = rom_n; ram_sel_n = ram_n;
        rd_en_n = rd_n; wr_en_n = wr_n;
        @(negedge clk);
    endtask

    task automatic ram_read(input logic [17:0] a, input string req);
        op(a, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(req, {data_oe, data_out}, {1'b1, model[a[RAM_AW-1:0]]});
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R1", {data_oe, data_out}, 9'h000);
        rst_n = 1'b1;

        // R6: fill the RAM with the read strobe toggling and alias bits set.
        for (int i = 0; i < DEPTH; i++) begin
            logic [17:0] a;
            logic [7:0]  d;
            a = {i[7:0] ^ 8'h5A, i[9:0]};
            d = 8'(i * 37 + 5);
            op(a, d, 1'b1, 1'b0, i[0], 1'b0);
            model[i] = d;
            chk("R6", {8'h00, data_oe}, 9'h000);
        end

        // R4/R8: read everything back through different alias bits.
        for (int i = 0; i < DEPTH; i++)
            ram_read({i[7:0] ^ 8'hC3, i[9:0]}, "R4_R8");

        // R10: a write and an immediate read of the same word.
        for (int i = 0; i < 64; i++) begin
            logic [9:0] w;
            w = 10'(i * 97 + 3);
            op({8'h11, w}, 8'(~i * 13), 1'b1, 1'b0, 1'b1, 1'b0);
            model[w] = 8'(~i * 13);
            ram_read({8'hEE, w}, "R10");
        end

        // R3/R9: ROM sweep with the write strobe toggling and a busy din.
        for (int i = 0; i < (1 << ROM_AW); i += 37) begin
            logic [17:0] a;
            a = 18'(i);
            op(a, 8'(i + 1), 1'b0, 1'b1, 1'b0, i[0]);
            chk("R3", {data_oe, data_out}, {1'b1, rom_exp(a)});
        end
        op(18'h3FFFF, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3", {data_oe, data_out}, {1'b1, rom_exp(18'h3FFFF)});
        for (int i = 0; i < DEPTH; i += 7)
            ram_read(18'(i), "R9");

        // R2: standby with every strobe combination, including a write.
        for (int k = 0; k < 4; k++) begin
            op(18'h00005, 8'hFF, 1'b1, 1'b1, k[0], k[1]);
            chk("R2", {8'h00, data_oe}, 9'h000);
        end
        ram_read(18'h00005, "R2");

        // R7: both selects low with a write attempt; no output, no write.
        for (int k = 0; k < 4; k++) begin
            op(18'h00009, ~model[9], 1'b0, 1'b0, k[0], k[1]);
            chk("R7", {8'h00, data_oe}, 9'h000);
        end
        ram_read(18'h00009, "R7");

        // R5: an array selected with the read strobe high.
        op(18'h00100, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R5", {8'h00, data_oe}, 9'h000);
        op(18'h00100, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R5", {8'h00, data_oe}, 9'h000);

        // R1: reset in the middle of a read stream clears the output.
        op(18'h00200, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", {data_oe, data_out}, 9'h000);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule